// File: doc/BRIEF.md
# DSP-Format Serial Audio Transmitter with Mono Mode

This block serializes one frame of audio per frame-sync pulse onto a single data line. It runs directly on the bit clock. A one-cycle frame-sync pulse starts each frame. The block takes a left and a right sample, each MSB-justified in a 32-bit word. A 2-bit word-length code sets how many bits of each sample go out, MSB first. In stereo framing the left word goes out and the right word follows with no gap. After that the line is held low until the next pulse.

Mono mode is enabled by a control bit and works only when the format code selects DSP framing. It sends one word per frame. The two channel enables pick the word, and the right channel wins when both are set. Each channel has an invert control that negates its sample in two's complement at the chosen word length before it is sent. A registered error flag reports a mono setup whose frame length is not shorter than two word lengths.

Top module: `dsp_mono_tx`

## Requirements
- R1: While reset is high, and on the first cycle after reset, both `sdata` and `mono_err` are 0.
- R2: The word-length code selects 16, 20, 24 or 32 bits for codes 00, 01, 10 and 11. Each word sends bits [31], [30], and so on, down to [32-L] of its sample. Bit k of a frame is on `sdata` in the cycle that follows the k-th clock edge after the edge that sampled `fsync` high (k counts from 0).
- R3: In stereo framing the left word goes first and the right word starts on the very next bit clock. Every later bit of the frame is 0.
- R4: Mono framing is active only when `mono_en` is 1 and `fmt` is 2'b11. With any other format code, the block sends stereo frames whatever the value of `mono_en`.
- R5: In mono framing exactly one word is sent at the start of the frame. The rest of the frame is 0.
- R6: In mono framing, the right sample is sent when `ena_r` is 1, whatever `ena_l` is. The left sample is sent when only `ena_l` is 1.
- R7: In mono framing with both channel enables 0, every bit of the frame is 0.
- R8: When a channel's invert bit is 1, the word sent is the two's-complement negation, modulo 2^L, of that channel's L-bit word. The most negative value is sent unchanged.
- R9: `mono_err` is 1 in the cycle after any clock edge at which mono framing is active and `frame_len` is at least twice the word length. Otherwise it is 0 in the cycle after the edge.
- R10: Samples, word length, enables, invert bits and mode are captured at the edge that samples `fsync`. Changing them later in the frame does not alter the frame being sent.
- R11: A new `fsync` pulse restarts framing with the new frame's first bit, even if the previous frame's words were not finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | One-cycle frame-sync pulse |
| fmt | input | 2 | Interface format code; 2'b11 is DSP framing |
| mono_en | input | 1 | Mono mode request |
| wl_code | input | 2 | Word length code (16/20/24/32) |
| frame_len | input | FLEN_W | Bit clocks per frame, used for the mono legality check |
| ena_l | input | 1 | Left channel enable (mono selection) |
| ena_r | input | 1 | Right channel enable (mono selection) |
| inv_l | input | 1 | Negate left sample |
| inv_r | input | 1 | Negate right sample |
| left_word | input | 32 | Left sample, MSB-justified |
| right_word | input | 32 | Right sample, MSB-justified |
| sdata | output | 1 | Serial data out, registered |
| mono_err | output | 1 | Illegal mono frame length flag, registered |

## Verification
The assertions assume that `fsync` is a clean pulse. They also assume that the controls seen at each edge are settled values, and they check decode and serializer behaviour relative to those values. The bench changes inputs only on falling edges and raises `fsync` for exactly one cycle per frame. It keeps `frame_len` equal to the real spacing between pulses, except in one frame that is deliberately cut short. It drives the controls mid-frame only to show that they are ignored until the next pulse.

// File: rtl/dmt_pkg.sv
package dmt_pkg;
  localparam int SAMPLE_W = 32;
  localparam int WLB_W    = 7;

  typedef enum logic [1:0] {
    SRC_NONE  = 2'b00,
    SRC_LEFT  = 2'b01,
    SRC_RIGHT = 2'b10,
    SRC_BOTH  = 2'b11
  } src_e;

  function automatic logic [WLB_W-1:0] wl_bits(input logic [1:0] code);
    case (code)
      2'b00:   wl_bits = 7'd16;
      2'b01:   wl_bits = 7'd20;
      2'b10:   wl_bits = 7'd24;
      default: wl_bits = 7'd32;
    endcase
  endfunction
endpackage

// File: rtl/dmt_cfg_decode.sv
module dmt_cfg_decode
  import dmt_pkg::*;
#(
  parameter int FLEN_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        fmt,
  input  logic              mono_en,
  input  logic [1:0]        wl_code,
  input  logic [FLEN_W-1:0] frame_len,
  input  logic              ena_l,
  input  logic              ena_r,
  output logic [WLB_W-1:0]  wl,
  output src_e              src,
  output logic              mono_err
);
  localparam int CW = (FLEN_W > WLB_W + 1) ? FLEN_W : WLB_W + 1;
  localparam logic [1:0] FMT_DSP = 2'b11;

  logic          mono_act;
  logic [CW-1:0] len_x;
  logic [CW-1:0] twice_x;
  logic          err_q;

  assign wl       = wl_bits(wl_code);
  assign mono_act = mono_en && (fmt == FMT_DSP);
  assign len_x    = CW'(frame_len);
  assign twice_x  = CW'({wl, 1'b0});

  always_comb begin
    if (!mono_act)  src = SRC_BOTH;
    else if (ena_r) src = SRC_RIGHT;
    else if (ena_l) src = SRC_LEFT;
    else            src = SRC_NONE;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= 1'b0;
    else     err_q <= mono_act && (len_x >= twice_x);
  end

  assign mono_err = err_q;

  a_r6_right_wins: assert property (@(posedge clk) disable iff (rst)
    (mono_en && fmt == FMT_DSP && ena_r) |-> (src == SRC_RIGHT));
  a_r4_dsp_only: assert property (@(posedge clk) disable iff (rst)
    (fmt != FMT_DSP) |-> (src == SRC_BOTH));
  a_r9_err_needs_mono: assert property (@(posedge clk) disable iff (rst)
    mono_err |-> ($past(mono_en) && $past(fmt) == FMT_DSP));
endmodule

// File: rtl/dmt_word_prep.sv
module dmt_word_prep
  import dmt_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [W-1:0]     sample,
  input  logic [WLB_W-1:0] wl,
  input  logic             inv,
  output logic [W-1:0]     word
);
  logic [W-1:0] keep_mask;
  logic [W-1:0] masked;
  logic [W-1:0] top_only;

  assign keep_mask = ~({W{1'b1}} >> wl);
  assign masked    = sample & keep_mask;
  assign word      = inv ? (~masked + 1'b1) : masked;
  assign top_only  = {1'b1, {(W-1){1'b0}}};

  a_r8_sign_flips: assert property (@(posedge clk) disable iff (rst)
    (inv && masked != '0 && masked != top_only) |-> (word[W-1] != masked[W-1]));
  a_r2_tail_clear: assert property (@(posedge clk) disable iff (rst)
    ((word & ~keep_mask) == '0));
endmodule

// File: rtl/dmt_serializer.sv
module dmt_serializer
  import dmt_pkg::*;
#(
  parameter int W = SAMPLE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  input  src_e             src,
  input  logic [WLB_W-1:0] wl,
  input  logic [W-1:0]     word_l,
  input  logic [W-1:0]     word_r,
  output logic             sdata
);
  localparam int PW = 2 * W;

  logic [PW-1:0] pk_new;
  logic [PW-1:0] pk_q;
  logic          sd_q;

  always_comb begin
    case (src)
      SRC_LEFT:  pk_new = {word_l, {W{1'b0}}};
      SRC_RIGHT: pk_new = {word_r, {W{1'b0}}};
      SRC_BOTH:  pk_new = {word_l, {W{1'b0}}} | ({word_r, {W{1'b0}}} >> wl);
      default:   pk_new = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pk_q <= '0;
      sd_q <= 1'b0;
    end else if (fsync) begin
      sd_q <= pk_new[PW-1];
      pk_q <= pk_new << 1;
    end else begin
      sd_q <= pk_q[PW-1];
      pk_q <= pk_q << 1;
    end
  end

  assign sdata = sd_q;

  a_r7_none_silent: assert property (@(posedge clk) disable iff (rst)
    (fsync && src == SRC_NONE) |=> !sdata);
  a_r3_drained_quiet: assert property (@(posedge clk) disable iff (rst)
    (!fsync && pk_q == '0) |=> !sdata);
endmodule

// File: rtl/dsp_mono_tx.sv
module dsp_mono_tx
  import dmt_pkg::*;
#(
  parameter int FLEN_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fsync,
  input  logic [1:0]        fmt,
  input  logic              mono_en,
  input  logic [1:0]        wl_code,
  input  logic [FLEN_W-1:0] frame_len,
  input  logic              ena_l,
  input  logic              ena_r,
  input  logic              inv_l,
  input  logic              inv_r,
  input  logic [31:0]       left_word,
  input  logic [31:0]       right_word,
  output logic              sdata,
  output logic              mono_err
);
  localparam int NCH = 2;

  logic [WLB_W-1:0]          wl;
  src_e                      src;
  logic [NCH-1:0][SAMPLE_W-1:0] samples;
  logic [NCH-1:0][SAMPLE_W-1:0] words;
  logic [NCH-1:0]            invs;

  assign samples = {right_word, left_word};
  assign invs    = {inv_r, inv_l};

  dmt_cfg_decode #(.FLEN_W(FLEN_W)) u_dec (
    .clk(clk), .rst(rst), .fmt(fmt), .mono_en(mono_en), .wl_code(wl_code),
    .frame_len(frame_len), .ena_l(ena_l), .ena_r(ena_r),
    .wl(wl), .src(src), .mono_err(mono_err)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dmt_word_prep #(.W(SAMPLE_W)) u_prep (
      .clk(clk), .rst(rst), .sample(samples[c]), .wl(wl),
      .inv(invs[c]), .word(words[c])
    );
  end

  dmt_serializer #(.W(SAMPLE_W)) u_ser (
    .clk(clk), .rst(rst), .fsync(fsync), .src(src), .wl(wl),
    .word_l(words[0]), .word_r(words[1]), .sdata(sdata)
  );

  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!sdata && !mono_err));
endmodule

// File: tb/dsp_mono_tx_bench.sv
module dsp_mono_tx_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fsync = 1'b0;
  logic [1:0]  fmt = 2'b11;
  logic        mono_en = 1'b0;
  logic [1:0]  wl_code = 2'b00;
  logic [8:0]  frame_len = 9'd64;
  logic        ena_l = 1'b0, ena_r = 1'b0, inv_l = 1'b0, inv_r = 1'b0;
  logic [31:0] left_word = '0, right_word = '0;
  logic        sdata, mono_err;

  int n_chk = 0, n_bad = 0;
  logic  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  dsp_mono_tx u_dsp_mono_tx (
    .clk(clk), .rst(rst), .fsync(fsync), .fmt(fmt), .mono_en(mono_en),
    .wl_code(wl_code), .frame_len(frame_len), .ena_l(ena_l), .ena_r(ena_r),
    .inv_l(inv_l), .inv_r(inv_r), .left_word(left_word), .right_word(right_word),
    .sdata(sdata), .mono_err(mono_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // Scoreboard monitor: one expected bit per cycle after the frame edge
  initial forever begin
    @(posedge clk);
    #2;
    if (exp_q.size() > 0) begin
      logic  e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, sdata, e);
    end
  end

  // Driver: applies one frame and pushes its expected bits
  task automatic frame(input logic [1:0] f, input logic m, input logic [1:0] wc,
                       input logic el, input logic er, input logic il, input logic ir,
                       input logic [31:0] lw, input logic [31:0] rw,
                       input int len, input string tag, input bit scramble);
    int w, n;
    logic [31:0] ml, mr, xl, xr, first, second;
    w  = (wc == 2'b00) ? 16 : (wc == 2'b01) ? 20 : (wc == 2'b10) ? 24 : 32;
    ml = lw & ~(32'hFFFF_FFFF >> w);
    mr = rw & ~(32'hFFFF_FFFF >> w);
    xl = il ? (32'd0 - ml) : ml;
    xr = ir ? (32'd0 - mr) : mr;
    first = '0; second = '0;
    if (!(m && f == 2'b11)) begin n = 2; first = xl; second = xr; end
    else if (er)           begin n = 1; first = xr; end
    else if (el)           begin n = 1; first = xl; end
    else                          n = 0;
    @(negedge clk);
    fmt = f; mono_en = m; wl_code = wc; ena_l = el; ena_r = er;
    inv_l = il; inv_r = ir; left_word = lw; right_word = rw;
    frame_len = 9'(len); fsync = 1'b1;
    for (int k = 0; k < len; k++) begin
      logic b;
      if (k >= n * w)  b = 1'b0;
      else if (k < w)  b = first[31 - k];
      else             b = second[31 - (k - w)];
      exp_q.push_back(b);
      tag_q.push_back(tag);
    end
    @(negedge clk);
    fsync = 1'b0;
    if (scramble) begin
      left_word = ~lw; right_word = ~rw; inv_l = ~il; inv_r = ~ir;
      wl_code = ~wc; mono_en = ~m; ena_l = ~el; ena_r = ~er;
    end
    repeat (len - 2) @(negedge clk);
  endtask

  task automatic err_case(input logic [1:0] f, input logic m, input logic [1:0] wc,
                          input int len, input logic exp, input string tag);
    @(negedge clk);
    fmt = f; mono_en = m; wl_code = wc; frame_len = 9'(len);
    @(negedge clk);
    check(tag, mono_err, exp);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", sdata, 1'b0);
    check("R1", mono_err, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", sdata, 1'b0);
    check("R1", mono_err, 1'b0);

    frame(2'b11, 0, 2'b00, 1, 1, 0, 0, 32'hA5C3_1234, 32'h5A3C_8765, 40, "R2", 0);
    frame(2'b11, 0, 2'b01, 0, 0, 0, 0, 32'hF00F_1E3C, 32'h1234_5678, 48, "R2", 0);
    frame(2'b11, 0, 2'b10, 1, 0, 0, 0, 32'h8001_7FFF, 32'hC0FF_EE11, 56, "R3", 0);
    frame(2'b11, 0, 2'b11, 0, 1, 0, 0, 32'hDEAD_BEEF, 32'h0BAD_F00D, 64, "R3", 0);
    frame(2'b11, 0, 2'b11, 0, 0, 0, 0, 32'h1357_9BDF, 32'hFFFF_0001, 40, "R11", 0);
    frame(2'b10, 1, 2'b00, 1, 1, 0, 0, 32'h9999_0000, 32'h6666_0000, 40, "R4", 0);
    frame(2'b00, 1, 2'b01, 0, 1, 0, 0, 32'h7654_3210, 32'h0123_4567, 44, "R4", 0);
    frame(2'b11, 1, 2'b00, 1, 0, 0, 0, 32'hB00C_0000, 32'h4444_0000, 24, "R5", 0);
    frame(2'b11, 1, 2'b10, 1, 1, 0, 0, 32'h1111_1100, 32'hABCD_EF00, 40, "R6", 0);
    frame(2'b11, 1, 2'b11, 0, 1, 0, 0, 32'h1111_1111, 32'h8888_4444, 40, "R6", 0);
    frame(2'b11, 1, 2'b01, 0, 0, 0, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 30, "R7", 0);
    frame(2'b11, 0, 2'b00, 0, 0, 1, 1, 32'h0001_0000, 32'h8000_0000, 36, "R8", 0);
    frame(2'b11, 0, 2'b10, 0, 0, 1, 0, 32'h1234_5600, 32'h00FF_0000, 52, "R8", 0);
    frame(2'b11, 1, 2'b11, 0, 1, 0, 1, 32'h0, 32'h0000_0003, 40, "R8", 0);
    frame(2'b11, 0, 2'b00, 1, 0, 0, 1, 32'hCAFE_0000, 32'h7001_0000, 40, "R10", 1);
    frame(2'b11, 1, 2'b00, 1, 0, 1, 0, 32'h4321_0000, 32'h0, 20, "R10", 1);
    repeat (3) @(negedge clk);

    err_case(2'b11, 1, 2'b00, 32, 1'b1, "R9");
    err_case(2'b11, 1, 2'b00, 31, 1'b0, "R9");
    err_case(2'b11, 1, 2'b11, 64, 1'b1, "R9");
    err_case(2'b11, 1, 2'b11, 63, 1'b0, "R9");
    err_case(2'b10, 1, 2'b00, 200, 1'b0, "R9");
    err_case(2'b11, 0, 2'b00, 200, 1'b0, "R9");
    err_case(2'b11, 1, 2'b01, 50, 1'b1, "R9");
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1", mono_err, 1'b0);
    check("R1", sdata, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule